// File: doc/BRIEF.md
# Reset Source Discrimination Sequencer

This block decides why a chip went into reset and picks the reset vector the core fetches from. Three things can put the core into reset. The power-on flag is one. A low level driven onto the bidirectional reset pin from outside the chip is another. The third is an internal request from the watchdog or the clock monitor, and that request carries a source tag.

Entry into core reset is combinational: it needs no clock edge. Exit from core reset happens only after a clocked sequence has run.

When an internal request arrives, the block pulls the open-drain reset pin low for a fixed number of clock cycles and then lets go. It waits a fixed settle window and then samples the pin. It reads the pin through a synchronizer.

- If the pin has come back high, the request is credited to its tagged internal source.
- If the pin is still low, something outside is holding it, and the reset is classified as external.

External resets and power-on share the normal vector. The watchdog and the clock monitor each have their own vector code.

Top module: `rst_cause_seq`

## Requirements
- R1: While `por_n` is low, the outputs are `core_rst_n` = 0, `pin_pull` = 0 and `vec_sel` = 0. After `por_n` goes high with the pin high, `core_rst_n` rises on the 4th rising clock edge and not before.
- R2: Core reset entry is asynchronous. `int_req` = 1, `pin_in` = 0 or `por_n` = 0 each drive `core_rst_n` low within the same cycle, with no clock edge needed.
- R3: An internal request seen in the run state sets `pin_pull` high from the next edge. It stays high for exactly `PULL_CYC` (16) cycles and then drops.
- R4: The pin is sampled on the `SAMPLE_DLY`th (8th) edge after `pin_pull` drops. If the sample is high, `vec_sel` becomes the tagged source's code: 2 for watchdog (`int_src` = 0), 1 for clock monitor (`int_src` = 1).
- R5: The core reset is released one cycle after an internal decision. `core_rst_n` rises on the 9th edge after `pin_pull` drops and is still low on the edge where `pin_pull` drops.
- R6: If the reset is classed as external, `vec_sel` = 0. Once the pin is high again, `core_rst_n` rises on the 4th edge after the pin rises.
- R7: If an external low starts together with an internal request and lasts at least 32 cycles, the reset is classed as external (`vec_sel` = 0), even though the pull-down sequence still runs.
- R8: A pin low seen in the run state with no internal request starts no pull-down. The reset is classed as external with `vec_sel` = 0.
- R9: Requests that arrive while a sequence is running are ignored. They do not stretch the pull-down window and do not change the source that gets credited.
- R10: `vec_sel` holds the last decision for as long as the core is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that paces the sequence |
| por_n | input | 1 | Power-on flag, active low; also the synchronous block reset |
| pin_in | input | 1 | Level read back from the reset pin (raw, asynchronous) |
| int_req | input | 1 | Internal reset request |
| int_src | input | 1 | Source tag of the request: 0 watchdog, 1 clock monitor |
| pin_pull | output | 1 | Enable for the open-drain pull-down on the reset pin |
| core_rst_n | output | 1 | Reset to the core, active low |
| vec_sel | output | 2 | Vector code: 0 normal, 1 clock monitor, 2 watchdog |

## Verification
Most results are due a fixed number of edges after their stimulus:

| Result | When it is due |
|---|---|
| Pull-down start | the edge after a request |
| Pull-down end | 16 edges after it starts |
| Sample point and vector update | 8 edges after the pull-down ends |
| Core release after an internal decision | 9 edges after the pull-down ends |
| Core release after the pin rises | 4 edges after the rise (2 synchronizer stages, the wait-state exit, the release stage) |

The asynchronous entry has no edge at all and is checked one time step after the input changes. The bench drives and samples on falling edges and counts falling edges from each stimulus. At each of these points it checks both the last cycle before the expected change and the cycle of the change itself, so an off-by-one in any counter or stage shows up as a failure.

// File: rtl/rcs_pkg.sv
// Shared types for the reset source discrimination sequencer.
// Assumes: vector codes are decoded by the core's vector fetch logic.
package rcs_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_PULL   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_EXTW   = 3'd3,
        ST_DONE   = 3'd4
    } rcs_state_e;

    typedef enum logic [1:0] {
        VEC_NORMAL = 2'd0,
        VEC_CLKMON = 2'd1,
        VEC_WDOG   = 2'd2
    } rcs_vec_e;

    // Source tag value on int_src
    localparam logic SRC_WDOG   = 1'b0;
    localparam logic SRC_CLKMON = 1'b1;

    // Map a latched source tag to its vector code
    function automatic rcs_vec_e src_to_vec(input logic src);
        return (src == SRC_CLKMON) ? VEC_CLKMON : VEC_WDOG;
    endfunction

endpackage

// File: rtl/rcs_sync.sv
// Multi-stage synchronizer for the asynchronous reset pin level.
// Assumes: STAGES >= 1; the chain resets to RST_VAL (pin read as low).
module rcs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop capture
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the pin level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rcs_ctrl.sv
// Sequencing state machine: times the pull-down, times the settle
// window, samples the synchronized pin and records the vector code.
// Assumes: pin_hi is already synchronized; int_req is only acted upon
// in the run state.
module rcs_ctrl
    import rcs_pkg::*;
#(
    parameter int PULL_CYC   = 16,
    parameter int SAMPLE_DLY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       int_req,
    input  logic       int_src,
    input  logic       pin_hi,
    output logic       pull,
    output logic       run,
    output logic [1:0] vec
);

    localparam int CNT_MAX = (PULL_CYC > SAMPLE_DLY) ? PULL_CYC : SAMPLE_DLY;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] PULL_LAST   = CNT_W'(PULL_CYC - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_DLY - 1);

    rcs_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             src_q;
    rcs_vec_e         vec_q;

    // State, window counter, latched source and decided vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_EXTW;
            cnt   <= '0;
            src_q <= SRC_WDOG;
            vec_q <= VEC_NORMAL;
        end else begin
            case (st)
                ST_RUN: begin
                    if (int_req) begin
                        st    <= ST_PULL;
                        cnt   <= '0;
                        src_q <= int_src;
                    end else if (!pin_hi) begin
                        st    <= ST_EXTW;
                        vec_q <= VEC_NORMAL;
                    end
                end
                ST_PULL: begin
                    if (cnt == PULL_LAST) begin
                        st  <= ST_SETTLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SETTLE: begin
                    if (cnt == SAMPLE_LAST) begin
                        cnt <= '0;
                        if (pin_hi) begin
                            vec_q <= src_to_vec(src_q);
                            st    <= ST_DONE;
                        end else begin
                            vec_q <= VEC_NORMAL;
                            st    <= ST_EXTW;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_EXTW: begin
                    if (pin_hi) st <= ST_DONE;
                end
                ST_DONE: st <= ST_RUN;
                default: st <= ST_EXTW;
            endcase
        end
    end

    assign pull = (st == ST_PULL);
    assign run  = (st == ST_RUN);
    assign vec  = vec_q;

endmodule

// File: rtl/rst_cause_seq.sv
// Top of the reset source discrimination sequencer.
// Asynchronous entry: any reset cause drops core_rst_n combinationally.
// Synchronous exit: only the sequencer's run state releases the core.
// Assumes: por_n is the block's synchronous active-low reset as well
// as the power-on cause; pin_in is the raw pin level.
module rst_cause_seq #(
    parameter int PULL_CYC    = 16,
    parameter int SAMPLE_DLY  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_in,
    input  logic       int_req,
    input  logic       int_src,
    output logic       pin_pull,
    output logic       core_rst_n,
    output logic [1:0] vec_sel
);

    logic pin_hi;
    logic run;

    rcs_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_sync (
        .clk  (clk),
        .rst_n(por_n),
        .d    (pin_in),
        .q    (pin_hi)
    );

    rcs_ctrl #(
        .PULL_CYC  (PULL_CYC),
        .SAMPLE_DLY(SAMPLE_DLY)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (por_n),
        .int_req(int_req),
        .int_src(int_src),
        .pin_hi (pin_hi),
        .pull   (pin_pull),
        .run    (run),
        .vec    (vec_sel)
    );

    // Combine clocked release with asynchronous entry causes
    assign core_rst_n = por_n & run & ~int_req & pin_in;

endmodule

// File: rtl/rcs_chk.sv
// Assertion checker for rst_cause_seq, attached with bind.
// Assumes: por_n low disables all properties.
module rcs_chk #(
    parameter int PULL_CYC = 16
) (
    input logic       clk,
    input logic       por_n,
    input logic       pin_pull,
    input logic       core_rst_n,
    input logic [1:0] vec_sel
);

    localparam int LEN_W = $clog2(PULL_CYC + 1) + 1;

    logic [LEN_W-1:0] pull_len;

    // Length of the current pull-down run in sampled cycles
    always_ff @(posedge clk) begin
        if (!por_n)        pull_len <= '0;
        else if (pin_pull) pull_len <= pull_len + LEN_W'(1);
        else               pull_len <= '0;
    end

    // R3
    pull_not_too_long_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull |-> (pull_len < LEN_W'(PULL_CYC)));

    // R3
    pull_exact_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_pull) |-> (pull_len == LEN_W'(PULL_CYC)));

    // R5
    held_at_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_pull) |-> !core_rst_n);

    // R10
    vec_stable_run_chk: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst_n && $past(core_rst_n)) |-> $stable(vec_sel));

    // R4
    vec_legal_chk: assert property (@(posedge clk) disable iff (!por_n)
        vec_sel != 2'd3);

endmodule

bind rst_cause_seq rcs_chk #(.PULL_CYC(PULL_CYC)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .pin_pull  (pin_pull),
    .core_rst_n(core_rst_n),
    .vec_sel   (vec_sel)
);

// File: tb/rst_cause_seq_tb.sv
// Directed bench for rst_cause_seq. Inputs change and outputs are
// sampled on falling edges; the pin is modelled as open drain with
// an optional external hold-low.
module rst_cause_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       int_req = 1'b0;
    logic       int_src = 1'b0;
    logic       ext_low = 1'b0;
    logic       pin_in;
    logic       pin_pull;
    logic       core_rst_n;
    logic [1:0] vec_sel;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Open-drain pin: low if the block or the outside pulls it
    assign pin_in = !(pin_pull || ext_low);

    rst_cause_seq u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .pin_in    (pin_in),
        .int_req   (int_req),
        .int_src   (int_src),
        .pin_pull  (pin_pull),
        .core_rst_n(core_rst_n),
        .vec_sel   (vec_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Core held for 3 falling edges after pin/por release, freed on the 4th
    task automatic chk_release4(input string req);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk({req, " core still held"}, core_rst_n, 0);
        end
        @(negedge clk);
        chk({req, " core released"}, core_rst_n, 1);
    endtask

    // R1 R2: power-on
    task automatic t_por();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 core in reset", core_rst_n, 0);
        chk("R1 no pull", pin_pull, 0);
        chk("R1 vec normal", vec_sel, 0);
        chk("R2 por async hold", core_rst_n, 0);
        por_n = 1'b1;
        chk_release4("R1");
    endtask

    // R2 R3 R4 R5 R9: internal request with pin free
    task automatic t_internal(input logic src, input int exp_vec, input bit glitch);
        @(negedge clk);
        int_req = 1'b1;
        int_src = src;
        #1;
        chk("R2 int_req async entry", core_rst_n, 0);
        @(negedge clk);
        int_req = 1'b0;
        chk("R3 pull starts", pin_pull, 1);
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            if (glitch && i == 5) begin
                int_req = 1'b1;
                int_src = ~src;
            end else begin
                int_req = 1'b0;
            end
            chk("R3 pull held", pin_pull, 1);
        end
        @(negedge clk);
        int_req = 1'b0;
        chk("R3 pull ends after 16", pin_pull, 0);
        chk("R5 core held at release", core_rst_n, 0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk("R5 core held in settle", core_rst_n, 0);
        end
        chk("R4 vec from source", vec_sel, exp_vec);
        if (glitch) chk("R9 source unchanged by late request", vec_sel, exp_vec);
        @(negedge clk);
        chk("R5 core released", core_rst_n, 1);
    endtask

    // R8 R6: external pin low in run state
    task automatic t_ext_run();
        bit saw_pull = 1'b0;
        @(negedge clk);
        ext_low = 1'b1;
        #1;
        chk("R2 pin async entry", core_rst_n, 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (pin_pull) saw_pull = 1'b1;
        end
        chk("R8 no pull for external", saw_pull, 0);
        chk("R8 vec normal", vec_sel, 0);
        ext_low = 1'b0;
        chk_release4("R6");
    endtask

    // R7 R6: long external hold overlapping an internal request
    task automatic t_ext_during();
        @(negedge clk);
        int_req = 1'b1;
        int_src = 1'b1;
        ext_low = 1'b1;
        for (int c = 1; c <= 32; c++) begin
            @(negedge clk);
            int_req = 1'b0;
            if (c == 1)  chk("R7 pull still runs", pin_pull, 1);
            if (c == 25) begin
                chk("R7 classed external", vec_sel, 0);
                chk("R7 core held", core_rst_n, 0);
            end
            if (c == 32) ext_low = 1'b0;
        end
        chk_release4("R6");
        chk("R6 vec normal", vec_sel, 0);
    endtask

    // R10: vector holds while running
    task automatic t_hold(input int exp_vec);
        repeat (20) @(negedge clk);
        chk("R10 vec held", vec_sel, exp_vec);
        chk("R10 core running", core_rst_n, 1);
    endtask

    initial begin
        fork
            begin
                t_por();
                t_internal(1'b0, 2, 1'b0);
                t_ext_run();
                t_internal(1'b1, 1, 1'b1);
                t_hold(1);
                t_ext_during();
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=finished");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule